// File: doc/BRIEF.md
# Reference Clock Auto-Switch Controller

This block decides which of two reference clock inputs feeds a downstream PLL. It runs on a free-running local clock and watches both references with activity monitors. Each monitor counts synchronized rising edges over a fixed window of local cycles. A monitor calls its reference lost when a window holds too few edges. It calls the reference healthy again only after a run of good windows.

In manual mode the select pin picks the reference. When the auto pin is raised, the block arms. The reference picked at that moment becomes the working input, and the other one becomes the standby. If the working input fails while armed, the block switches to the standby once and then stops acting on its own. After such a failover the select pin has no effect until the auto pin goes low again. Auto mode can only be re-armed by a low phase on the auto pin followed by a return to high.

Top module: `refsw_ctrl`

## Requirements
- R1: While the auto pin is low, the select pin alone picks the reference: 0 gives reference 0, 1 gives reference 1. `ref_ack_o` shows the index of the chosen input.
- R2: Raising the auto pin from manual mode arms the block. The input picked by the select pin at that moment stays the working reference.
- R3: `lor_o` always shows the lost status of the reference currently chosen: 1 when it is lost, 0 when it is active.
- R4: While armed, a loss on the working reference switches the choice to the other input, and `ref_ack_o` changes level.
- R5: Only one switch happens per arming. If the newly chosen input is also lost, the choice stays put and `lor_o` stays 1.
- R6: After a failover, and while the auto pin stays high, changes on the select pin have no effect on the choice.
- R7: Driving the auto pin low hands control back to the select pin. A later rise arms the block again, with the reference then picked as the working input.
- R8: A monitor marks its reference lost at the end of any window that counts fewer than `MIN_EDGES` synchronized rising edges.
- R9: A lost reference is marked active only after `GOOD_WINDOWS` consecutive windows that each reach `MIN_EDGES`.
- R10: Reset puts the block in manual mode with reference 0 chosen, not armed, and both monitors reporting lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 2 | The two reference clocks, bit n is reference n |
| sel_i | input | 1 | Manual reference select |
| auto_i | input | 1 | Auto mode enable |
| ref_ack_o | output | 1 | Index of the chosen reference |
| lor_o | output | 1 | Lost status of the chosen reference |

## Verification
The bench builds the block with a 32-cycle window, a floor of 2 edges and 2 good windows. At these values a loss is caught, and a return to health is confirmed, within about a hundred local cycles. This lets the full sequence fit in a short run: arm, fail over, the one-shot lockout, re-arm, and the second failover. The references toggle every 2.5 local cycles, which gives about six rising edges per window, well above the floor.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
   typedef enum logic [1:0] {
      MODE_MANUAL = 2'd0,
      MODE_ARMED  = 2'd1,
      MODE_SPENT  = 2'd2
   } refsw_mode_e;
endpackage

// File: rtl/refsw_sync.sv
module refsw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("refsw_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign q_o    = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/refsw_monitor.sv
module refsw_monitor #(
   parameter int WIN_CYCLES   = 32,
   parameter int MIN_EDGES    = 2,
   parameter int GOOD_WINDOWS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic lost_o
);
   localparam int WW = $clog2(WIN_CYCLES);
   localparam int EW = $clog2(MIN_EDGES + 1);
   localparam int GW = $clog2(GOOD_WINDOWS + 1);

   if (WIN_CYCLES < 4) begin : g_bad_win
      $error("refsw_monitor: WIN_CYCLES must be at least 4");
   end
   if (MIN_EDGES < 1 || MIN_EDGES >= WIN_CYCLES / 2) begin : g_bad_min
      $error("refsw_monitor: MIN_EDGES out of range");
   end
   if (GOOD_WINDOWS < 1) begin : g_bad_good
      $error("refsw_monitor: GOOD_WINDOWS must be at least 1");
   end

   logic [WW-1:0] win_q;
   logic [EW-1:0] cnt_q;
   logic [GW-1:0] run_q;
   logic          win_end;
   logic [EW:0]   cnt_sum;
   logic          win_good;
   logic [GW:0]   run_sum;

   assign win_end  = (win_q == WW'(WIN_CYCLES - 1));
   assign cnt_sum  = {1'b0, cnt_q} + (EW+1)'(edge_i);
   assign win_good = (cnt_sum >= (EW+1)'(MIN_EDGES));
   assign run_sum  = {1'b0, run_q} + (GW+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         cnt_q  <= '0;
         run_q  <= '0;
         lost_o <= 1'b1;
      end else if (win_end) begin
         win_q <= '0;
         cnt_q <= '0;
         if (!win_good) begin
            run_q  <= '0;
            lost_o <= 1'b1;
         end else if (run_sum >= (GW+1)'(GOOD_WINDOWS)) begin
            run_q  <= GW'(GOOD_WINDOWS);
            lost_o <= 1'b0;
         end else begin
            run_q <= run_sum[GW-1:0];
         end
      end else begin
         win_q <= win_q + WW'(1);
         if (!cnt_sum[EW] && cnt_sum[EW-1:0] <= EW'(MIN_EDGES))
            cnt_q <= cnt_sum[EW-1:0];
      end
   end

   // R8: a short window always ends in the lost state
   assert_short_window_lost_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !win_good) |=> lost_o);
   // R9: leaving the lost state needs a completed good window
   assert_recover_needs_good_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lost_o) |-> ($past(win_end) && $past(win_good)));
endmodule

// File: rtl/refsw_arbiter.sv
module refsw_arbiter
   import refsw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_i,
   input  logic       auto_i,
   input  logic [1:0] lost_i,
   output logic       cur_o
);
   refsw_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_MANUAL;
         cur_o  <= 1'b0;
      end else begin
         unique case (mode_q)
            MODE_MANUAL: begin
               cur_o <= sel_i;
               if (auto_i) mode_q <= MODE_ARMED;
            end
            MODE_ARMED: begin
               if (!auto_i) begin
                  mode_q <= MODE_MANUAL;
               end else if (lost_i[cur_o]) begin
                  cur_o  <= ~cur_o;
                  mode_q <= MODE_SPENT;
               end
            end
            MODE_SPENT: begin
               if (!auto_i) mode_q <= MODE_MANUAL;
            end
            default: mode_q <= MODE_MANUAL;
         endcase
      end
   end

   // R7: a low auto input always leads back to manual
   assert_low_auto_manual_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_i |=> (mode_q == MODE_MANUAL));
   // R2: arming keeps the input that was picked in manual mode
   assert_arm_keeps_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_ARMED && $past(mode_q) == MODE_MANUAL) |-> $stable(cur_o));
   // R4: a loss on the working input while armed flips the choice
   assert_failover_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_ARMED && auto_i && lost_i[cur_o]) |=> (cur_o != $past(cur_o)));
   // R5: a spent arming never returns straight to armed
   assert_one_shot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SPENT) |=> (mode_q != MODE_ARMED));
   // R6: the choice holds while spent and auto stays high
   assert_spent_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SPENT && auto_i) |=> $stable(cur_o));
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl #(
   parameter int SYNC_STAGES  = 2,
   parameter int WIN_CYCLES   = 32,
   parameter int MIN_EDGES    = 2,
   parameter int GOOD_WINDOWS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ref_i,
   input  logic       sel_i,
   input  logic       auto_i,
   output logic       ref_ack_o,
   output logic       lor_o
);
   localparam int NREF = 2;

   logic [NREF-1:0] ref_rise;
   logic [NREF-1:0] ref_lvl;
   logic [NREF-1:0] lost;
   logic            sel_s, auto_s;
   logic            sel_rise_unused, auto_rise_unused;
   logic            cur;

   for (genvar i = 0; i < NREF; i++) begin : g_ref
      refsw_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_i(ref_i[i]),
         .q_o(ref_lvl[i]), .rise_o(ref_rise[i]));
      refsw_monitor #(
         .WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES),
         .GOOD_WINDOWS(GOOD_WINDOWS)
      ) u_mon (
         .clk(clk), .rst_n(rst_n), .edge_i(ref_rise[i]), .lost_o(lost[i]));
   end

   refsw_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sel_i),
      .q_o(sel_s), .rise_o(sel_rise_unused));
   refsw_sync #(.STAGES(SYNC_STAGES)) u_auto_sync (
      .clk(clk), .rst_n(rst_n), .d_i(auto_i),
      .q_o(auto_s), .rise_o(auto_rise_unused));

   refsw_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_s), .auto_i(auto_s),
      .lost_i(lost), .cur_o(cur));

   assign ref_ack_o = cur;
   assign lor_o     = lost[cur];

   // R1: with auto held low the choice follows the synchronized select
   assert_manual_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_s && $past(!auto_s)) |=> (ref_ack_o == $past(sel_s)));
   // R3: the loss flag tracks the monitor of the chosen input
   assert_lor_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_ack_o ? (lor_o == lost[1]) : (lor_o == lost[0])));
endmodule

// File: tb/refsw_ctrl_bench.sv
module refsw_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ref_i = 2'b00;
   logic       sel_i = 1'b0;
   logic       auto_i = 1'b0;
   logic       en0 = 1'b0, en1 = 1'b0;
   logic       ref_ack_o, lor_o;
   int         n_checks = 0, n_fail = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   initial forever begin #25; if (en0) ref_i[0] = ~ref_i[0]; end
   initial forever begin #25; if (en1) ref_i[1] = ~ref_i[1]; end

   refsw_ctrl #(.SYNC_STAGES(2), .WIN_CYCLES(32), .MIN_EDGES(2), .GOOD_WINDOWS(2))
      u_refsw_ctrl (.clk(clk), .rst_n(rst_n), .ref_i(ref_i), .sel_i(sel_i),
                    .auto_i(auto_i), .ref_ack_o(ref_ack_o), .lor_o(lor_o));

   // fields: sel, auto, en0, en1, expected ack, expected lor, requirement number
   typedef struct packed {
      logic sel; logic aut; logic e0; logic e1; logic ack; logic lor; logic [3:0] req;
   } vec_t;
   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'd1},   // manual ref0
      '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,4'd1},   // manual ref1
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'd1},   // back to ref0
      '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,4'd2},   // arm on ref0
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'd4},   // ref0 dies: fail over
      '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd6},   // select toggled, ignored
      '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,4'd6},   // select back to 0, ignored
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,4'd6},   // ref0 returns, no move
      '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,4'd5},   // ref1 dies: one shot spent
      '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,4'd9},   // ref1 recovers
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,4'd6},   // set select 1
      '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,4'd7},   // drop auto
      '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,4'd2},   // re-arm on ref1
      '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd7},   // ref1 dies: rearmed failover
      '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,4'd7},   // manual again, control back
      '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,4'd3},   // chosen ref0 dead
      '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,4'd3}    // choose live ref1
   };

   task automatic check(input logic act, input logic exp, input string req, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      wait_cyc(3);
      // R10: reset state
      check(ref_ack_o, 1'b0, "R10", "ack in reset");
      check(lor_o, 1'b1, "R10", "lor in reset");
      rst_n = 1'b1;
      wait_cyc(2);
      check(lor_o, 1'b1, "R10", "lor before first window");
      en0 = 1'b1; en1 = 1'b1;
      wait_cyc(150);

      for (int v = 0; v < NV; v++) begin
         sel_i = VECS[v].sel; auto_i = VECS[v].aut;
         en0 = VECS[v].e0; en1 = VECS[v].e1;
         wait_cyc(150);
         check(ref_ack_o, VECS[v].ack, $sformatf("R%0d", VECS[v].req), $sformatf("vec %0d ack", v));
         check(lor_o, VECS[v].lor, $sformatf("R%0d", VECS[v].req), $sformatf("vec %0d lor", v));
      end

      // R8: loss caught within two windows, not instantly
      sel_i = 1'b0; auto_i = 1'b0; en0 = 1'b1; en1 = 1'b1;
      wait_cyc(150);
      en0 = 1'b0;
      wait_cyc(2);
      check(lor_o, 1'b0, "R8", "lor right after stop");
      wait_cyc(80);
      check(lor_o, 1'b1, "R8", "lor after windows without edges");
      // R9: one good window cannot clear the loss
      en0 = 1'b1;
      wait_cyc(20);
      check(lor_o, 1'b1, "R9", "lor after partial recovery");
      wait_cyc(130);
      check(lor_o, 1'b0, "R9", "lor after good windows");
      done = 1'b1;
   end

   initial begin
      wait (done == 1'b1 || $time > 64'd1_500_000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule